// File: doc/BRIEF.md
# Shift Status Flag Generator

This block works out the six arithmetic status flags (carry, overflow, auxiliary, zero, sign and parity) that follow a logical-left, logical-right or arithmetic-right shift of an 8, 16 or 32 bit operand. The shifter itself lives elsewhere. The block receives the operand as it was before the shift, the shifted result, the raw shift count, the shift kind and the operand size. It registers the flags once per accepted request.

Only the low five bits of the count matter. When those five bits are all zero the shift leaves the flags alone. In that case the block raises no valid strobe and keeps the flag outputs at their previous values. Overflow follows a separate rule for each shift kind. A left shift reports a change of the top bit. A right logical shift reports the old top bit, but only for a single-position shift. An arithmetic right shift never reports overflow. The auxiliary flag is raised for every shift that counts.

Top module: `sflag_gen`

## Requirements
- R1: A request with `in_valid` high, a masked count (`in_count[4:0]`) that is nonzero and a kind of 0 (left), 1 (logical right) or 2 (arithmetic right) raises `flags_valid` on the next rising clock edge and presents that request's flags.
- R2: `flags_valid` is low on the next edge, and every flag output keeps its previous value, when the masked count is zero (counts 0, 32, 64 and so on), when the kind is 3, or when `in_valid` is low.
- R3: The auxiliary flag is 1 for every accepted request. Count bits 5 and above have no effect, so a count of 33 behaves like a count of 1.
- R4: For a logical right shift, overflow equals the operand's top bit at the selected size when the masked count is 1, and is 0 for any other count.
- R5: For an arithmetic right shift, overflow is always 0.
- R6: For a left shift, overflow is the XOR of the top bit of the result and the top bit of the operand at the selected size.
- R7: For a logical right shift, carry is operand bit (count-1). It is 0 when the count exceeds the operand width.
- R8: For an arithmetic right shift, carry is bit (count-1) of the operand sign-extended beyond its width, so it equals the sign bit when the count exceeds the width.
- R9: For a left shift, carry is operand bit (width-count). It is 0 when the count exceeds the width, as for a 16-bit shift by 17.
- R10: Zero and sign come from the result at the selected size only. Operand and result bits above that size are ignored.
- R11: Parity is 1 when the low 8 result bits hold an even number of ones.
- R12: The size code is 0 for 8 bits, 1 for 16 bits and 2 for 32 bits. Code 3 is treated as 32 bits.
- R13: While reset is held, `flags_valid` and all flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_kind | input | 2 | Shift kind: 0 left, 1 logical right, 2 arithmetic right, 3 none |
| in_size | input | 2 | Operand size code |
| in_operand | input | 32 | Operand before the shift |
| in_result | input | 32 | Shifted result |
| in_count | input | 8 | Raw shift count |
| flags_valid | output | 1 | Flags updated by the previous request |
| flag_cf | output | 1 | Carry |
| flag_of | output | 1 | Overflow |
| flag_af | output | 1 | Auxiliary |
| flag_zf | output | 1 | Zero |
| flag_sf | output | 1 | Sign |
| flag_pf | output | 1 | Parity |

## Verification
Two things can happen in the same cycle: the output register loads fresh flags from one request, and the input sees a request that must leave the flags alone. The bench provokes this by sending a flag-changing shift and, on the very next cycle, a shift whose masked count is zero (count 32 or 0), a kind-3 request, or an idle cycle. It then checks that the valid strobe drops while all six flags still equal the values expected from the earlier shift. The sweep over every kind, size and count from 1 to 31 runs requests back to back, so each new request lands in the cycle right after the previous load.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

   typedef enum logic [1:0] {
      SK_LEFT  = 2'd0,
      SK_RIGHT = 2'd1,
      SK_ARITH = 2'd2,
      SK_NONE  = 2'd3
   } shift_kind_e;

   typedef struct packed {
      logic cf;
      logic of;
      logic af;
      logic zf;
      logic sf;
      logic pf;
   } flag_set_t;

endpackage

// File: rtl/sflag_carry.sv
module sflag_carry
   import sflag_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int MASK_W = 5
) (
   input  logic [LANE_W-1:0] op,
   input  logic [MASK_W-1:0] mcount,
   input  shift_kind_e       kind,
   output logic              cf
);
   localparam int LANE_BITS = $clog2(LANE_W) + 2;
   localparam int IDX_W     = (MASK_W + 1 > LANE_BITS) ? MASK_W + 1 : LANE_BITS;

   logic [IDX_W-1:0] cnt_x;
   logic [IDX_W-1:0] lane_x;
   logic [IDX_W-1:0] left_amt;
   logic [IDX_W-1:0] right_amt;
   logic             beyond;
   logic             left_bit;
   logic             right_bit;

   always_comb begin
      cnt_x     = IDX_W'(mcount);
      lane_x    = IDX_W'(LANE_W);
      beyond    = cnt_x > lane_x;
      left_amt  = lane_x - cnt_x;
      right_amt = cnt_x - IDX_W'(1);
      left_bit  = |(op & (LANE_W'(1) << left_amt));
      right_bit = |(op & (LANE_W'(1) << right_amt));
      unique case (kind)
         SK_LEFT:  cf = beyond ? 1'b0 : left_bit;
         SK_RIGHT: cf = beyond ? 1'b0 : right_bit;
         SK_ARITH: cf = beyond ? op[LANE_W-1] : right_bit;
         default:  cf = 1'b0;
      endcase
   end
endmodule

// File: rtl/sflag_lane.sv
module sflag_lane
   import sflag_pkg::*;
#(
   parameter int LANE_W = 8,
   parameter int MASK_W = 5
) (
   input  logic [LANE_W-1:0] op,
   input  logic [LANE_W-1:0] res,
   input  logic [MASK_W-1:0] mcount,
   input  shift_kind_e       kind,
   output flag_set_t         flags
);
   logic carry;

   sflag_carry #(
      .LANE_W (LANE_W),
      .MASK_W (MASK_W)
   ) u_carry (
      .op     (op),
      .mcount (mcount),
      .kind   (kind),
      .cf     (carry)
   );

   always_comb begin
      flags.cf = carry;
      flags.af = |mcount;
      flags.zf = (res == '0);
      flags.sf = res[LANE_W-1];
      flags.pf = ~^res[7:0];
      unique case (kind)
         SK_LEFT:  flags.of = res[LANE_W-1] ^ op[LANE_W-1];
         SK_RIGHT: flags.of = (mcount == MASK_W'(1)) && op[LANE_W-1];
         default:  flags.of = 1'b0;
      endcase
   end
endmodule

// File: rtl/sflag_gen.sv
module sflag_gen
   import sflag_pkg::*;
#(
   parameter  int N_SIZES = 3,
   parameter  int SIZE_W  = 2,
   parameter  int CNT_W   = 8,
   parameter  int MASK_W  = 5,
   localparam int DATA_W  = 8 << (N_SIZES - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_kind,
   input  logic [SIZE_W-1:0] in_size,
   input  logic [DATA_W-1:0] in_operand,
   input  logic [DATA_W-1:0] in_result,
   input  logic [CNT_W-1:0]  in_count,
   output logic              flags_valid,
   output logic              flag_cf,
   output logic              flag_of,
   output logic              flag_af,
   output logic              flag_zf,
   output logic              flag_sf,
   output logic              flag_pf
);
   generate
      if (N_SIZES < 1 || N_SIZES > 4) begin : g_bad_sizes
         $error("sflag_gen: N_SIZES must lie in 1..4");
      end
      if ((1 << SIZE_W) < N_SIZES) begin : g_bad_size_w
         $error("sflag_gen: SIZE_W too narrow for N_SIZES");
      end
      if (MASK_W > CNT_W || MASK_W < 1) begin : g_bad_mask
         $error("sflag_gen: MASK_W must lie in 1..CNT_W");
      end
   endgenerate

   shift_kind_e       kind;
   logic [MASK_W-1:0] mcount;
   logic [SIZE_W-1:0] size_sel;
   logic              accept;
   flag_set_t         lane_fs [N_SIZES];
   flag_set_t         nxt_fs;
   flag_set_t         cur_fs;

   generate
      if (CNT_W > MASK_W) begin : g_cnt_hi
         logic unused_cnt_hi;
         assign unused_cnt_hi = |in_count[CNT_W-1:MASK_W];
      end
   endgenerate

   always_comb begin
      kind     = shift_kind_e'(in_kind);
      mcount   = in_count[MASK_W-1:0];
      size_sel = (in_size >= SIZE_W'(N_SIZES)) ? SIZE_W'(N_SIZES - 1) : in_size;
      accept   = in_valid && (mcount != '0) && (kind != SK_NONE);
   end

   generate
      for (genvar g = 0; g < N_SIZES; g++) begin : g_lane
         localparam int LW = 8 << g;
         sflag_lane #(
            .LANE_W (LW),
            .MASK_W (MASK_W)
         ) u_lane (
            .op     (in_operand[LW-1:0]),
            .res    (in_result[LW-1:0]),
            .mcount (mcount),
            .kind   (kind),
            .flags  (lane_fs[g])
         );
      end
   endgenerate

   assign nxt_fs = lane_fs[size_sel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_valid <= 1'b0;
         cur_fs      <= '0;
      end else begin
         flags_valid <= accept;
         if (accept) begin
            cur_fs <= nxt_fs;
         end
      end
   end

   assign flag_cf = cur_fs.cf;
   assign flag_of = cur_fs.of;
   assign flag_af = cur_fs.af;
   assign flag_zf = cur_fs.zf;
   assign flag_sf = cur_fs.sf;
   assign flag_pf = cur_fs.pf;
endmodule

// File: rtl/sflag_gen_chk.sv
module sflag_gen_chk #(
   parameter int MASK_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        in_kind,
   input logic [MASK_W-1:0] count_low,
   input logic [7:0]        res_low,
   input logic              flags_valid,
   input logic              flag_cf,
   input logic              flag_of,
   input logic              flag_af,
   input logic              flag_zf,
   input logic              flag_sf,
   input logic              flag_pf
);
   logic       req_ok;
   logic [5:0] all_flags;

   assign req_ok    = in_valid && (count_low != '0) && (in_kind != 2'd3);
   assign all_flags = {flag_cf, flag_of, flag_af, flag_zf, flag_sf, flag_pf};

   p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ok |=> flags_valid);

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ok |=> (!flags_valid && $stable(all_flags)));

   p_aux_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      flags_valid |-> flag_af);

   p_shr_of_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_valid && $past(in_kind) == 2'd1 && $past(count_low) != MASK_W'(1)) |-> !flag_of);

   p_sar_of_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_valid && $past(in_kind) == 2'd2) |-> !flag_of);

   p_parity_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flags_valid |-> (flag_pf == ~^$past(res_low)));
endmodule

bind sflag_gen sflag_gen_chk #(
   .MASK_W (MASK_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_kind     (in_kind),
   .count_low   (in_count[MASK_W-1:0]),
   .res_low     (in_result[7:0]),
   .flags_valid (flags_valid),
   .flag_cf     (flag_cf),
   .flag_of     (flag_of),
   .flag_af     (flag_af),
   .flag_zf     (flag_zf),
   .flag_sf     (flag_sf),
   .flag_pf     (flag_pf)
);

// File: tb/sflag_gen_test.sv
module sflag_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_kind = 2'd0;
   logic [1:0]  in_size = 2'd0;
   logic [31:0] in_operand = '0;
   logic [31:0] in_result = '0;
   logic [7:0]  in_count = '0;
   logic        flags_valid, flag_cf, flag_of, flag_af, flag_zf, flag_sf, flag_pf;

   int total = 0;
   int bad = 0;
   logic [6:0] exp_out = '0;

   always #10 clk = ~clk;

   sflag_gen uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
      .in_size(in_size), .in_operand(in_operand), .in_result(in_result),
      .in_count(in_count), .flags_valid(flags_valid), .flag_cf(flag_cf),
      .flag_of(flag_of), .flag_af(flag_af), .flag_zf(flag_zf),
      .flag_sf(flag_sf), .flag_pf(flag_pf)
   );

   function automatic logic [5:0] ref_flags(input logic [1:0] k, input logic [1:0] sz,
                                             input logic [31:0] op, input logic [7:0] cnt,
                                             output logic [31:0] res);
      int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
      int mc = int'(cnt) & 31;
      logic [31:0] mask = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
      logic [31:0] opm = op & mask;
      logic [31:0] opt = opm >> (w - 1);
      logic sign = opt[0];
      logic [63:0] ext = {32'h0, opm};
      logic [63:0] sh;
      logic [31:0] tmp;
      logic [31:0] rt;
      logic cf, of;
      if (k == 2'd2 && sign) ext = ext | ~{32'h0, mask};
      sh = ext >> mc;
      case (k)
         2'd0:    res = (opm << mc) & mask;
         2'd1:    res = opm >> mc;
         default: res = sh[31:0] & mask;
      endcase
      if (k == 2'd0) begin
         tmp = opm >> (w - mc);
         cf = (mc > w) ? 1'b0 : tmp[0];
      end else begin
         sh = ext >> (mc - 1);
         cf = sh[0];
      end
      rt = res >> (w - 1);
      case (k)
         2'd0:    of = rt[0] ^ sign;
         2'd1:    of = (mc == 1) ? sign : 1'b0;
         default: of = 1'b0;
      endcase
      return {cf, of, 1'b1, res == 32'h0, rt[0], ~^res[7:0]};
   endfunction

   task automatic check(input string tag, input logic [6:0] exp);
      logic [6:0] got = {flags_valid, flag_cf, flag_of, flag_af, flag_zf, flag_sf, flag_pf};
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got(v,cf,of,af,zf,sf,pf)=%b expected=%b", tag, got, exp);
      end
   endtask

   // Drives one request at a falling edge, waits one clock, checks.
   task automatic step(input logic v, input logic [1:0] k, input logic [1:0] sz,
                       input logic [31:0] op, input logic [7:0] cnt,
                       input logic [31:0] junk, input string tag);
      logic [31:0] res;
      logic [5:0]  f = ref_flags(k, sz, op, cnt, res);
      in_valid   = v;
      in_kind    = k;
      in_size    = sz;
      in_operand = op;
      in_count   = cnt;
      in_result  = res | junk;
      if (v && (cnt[4:0] != 5'd0) && k != 2'd3) exp_out = {1'b1, f};
      else exp_out[6] = 1'b0;
      @(negedge clk);
      check(tag, exp_out);
   endtask

   task automatic t_reset;
      check("R13 reset state", 7'b0);
   endtask

   task automatic t_left;
      step(1, 0, 0, 32'h81, 8'd1, 0, "R6 R9 byte left by 1");
      step(1, 0, 0, 32'h40, 8'd1, 0, "R6 byte left sign change");
      step(1, 0, 1, 32'hC001, 8'd17, 0, "R9 word left by 17 carry clear");
      step(1, 0, 1, 32'h0001, 8'd16, 0, "R9 word left by 16");
      step(1, 0, 2, 32'h8000_0003, 8'd31, 0, "R6 R9 dword left by 31");
      step(1, 0, 0, 32'h03, 8'd2, 0, "R11 parity even result");
   endtask

   task automatic t_right;
      step(1, 1, 0, 32'h81, 8'd1, 0, "R4 R7 byte right by 1 top set");
      step(1, 1, 1, 32'h8004, 8'd3, 0, "R4 R7 word right by 3");
      step(1, 1, 0, 32'hFF, 8'd12, 0, "R7 byte right beyond width");
      step(1, 1, 2, 32'h8000_0000, 8'd31, 0, "R7 dword right by 31");
   endtask

   task automatic t_arith;
      step(1, 2, 0, 32'h80, 8'd10, 0, "R8 byte arith beyond width");
      step(1, 2, 1, 32'h8001, 8'd1, 0, "R5 R8 word arith by 1");
      step(1, 2, 2, 32'h7FFF_FFFF, 8'd31, 0, "R8 dword arith positive");
   endtask

   task automatic t_hold;
      step(1, 0, 0, 32'hC0, 8'd1, 0, "R1 load before hold");
      step(1, 1, 0, 32'h01, 8'd32, 0, "R2 count 32 ignored");
      step(1, 1, 0, 32'h01, 8'd0, 0, "R2 count 0 ignored");
      step(1, 3, 0, 32'h01, 8'd3, 0, "R2 kind 3 ignored");
      step(0, 1, 0, 32'h01, 8'd3, 0, "R2 idle ignored");
      step(1, 1, 0, 32'h01, 8'd1, 0, "R1 new load after hold");
   endtask

   task automatic t_count_hi;
      step(1, 1, 0, 32'h80, 8'd33, 0, "R3 count 33 acts as 1");
      step(1, 2, 1, 32'hF000, 8'hE4, 0, "R3 upper count bits ignored");
   endtask

   task automatic t_size;
      step(1, 1, 3, 32'h8000_0000, 8'd1, 0, "R12 size 3 as dword");
      step(1, 0, 0, 32'hFFFF_FF00, 8'd1, 32'hFFFF_FF00, "R10 byte upper bits ignored");
      step(1, 2, 1, 32'h1234_0000, 8'd4, 32'hABCD_0000, "R10 word upper bits ignored");
   endtask

   task automatic t_sweep;
      for (int k = 0; k < 3; k++)
         for (int sz = 0; sz < 3; sz++)
            for (int c = 1; c < 32; c++) begin
               logic [31:0] op = 32'h9E37_79B9 * (c + k * 7 + sz * 3);
               step(1, 2'(k), 2'(sz), op, 8'(c), 0, "R1 R4 R5 R6 R7 R8 R9 R10 R11 sweep");
            end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_left();
      t_right();
      t_arith();
      t_hold();
      t_count_hi();
      t_size();
      t_sweep();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule